// File: doc/BRIEF.md
# Half-Precision to 8-bit Normalized Integer Converter

This block takes a half-precision floating-point sample that is expected to lie in [0.0, 1.0] and turns it into an 8-bit unsigned normalized code. Exactly 0.0 becomes 0x00 and exactly 1.0 becomes 0xFF. Values in between are rounded to the nearest code, and an exact half rounds up. The arithmetic uses integers only. The significand, with its hidden bit set, is multiplied by 255 through one shift and one subtract. The product is right-shifted by an amount taken from the exponent, and a final add-one-and-halve step does the rounding.

The block is a single registered stage. A valid input sampled on a clock edge produces a valid result on the next edge. A separate flag marks inputs that are negative or greater than 1.0, and the code output for such inputs carries no meaning. When no input is offered, the output register keeps its last result.

Top module: `hf_unorm8_conv`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o`, `out_unorm_o` and `out_range_err_o` read 0 until the first valid input.
- R2: `out_valid_o` is high in exactly those cycles that directly follow a cycle with `in_valid_i` high.
- R3: Input 0x0000 (0.0) gives code 0x00, and input 0x3C00 (1.0) gives code 0xFF.
- R4: For every in-range input with an exponent field (bits 14:10) from 1 to 15, the code equals floor(value·255 + 0.5). For example, 0x3800 (0.5, an exact tie) gives 0x80.
- R5: Every input with sign bit 15 at 0 and exponent field 0 (zero and subnormals) gives code 0x00.
- R6: `out_range_err_o` is set for an accepted input whose bit 15 is 1, or whose bits 14:0 exceed 0x3C00. It is cleared for every other accepted input, and the flag appears in the same cycle as the code.
- R7: In a cycle where `in_valid_i` is low, `out_unorm_o` and `out_range_err_o` keep their previous values in the next cycle.
- R8: Inputs are accepted back to back, one per cycle, and every cycle's result belongs to the input of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input sample present |
| in_half_i | input | 16 | Half-precision input: sign bit 15, exponent 14:10, mantissa 9:0 |
| out_valid_o | output | 1 | Result present, one cycle after input |
| out_unorm_o | output | 8 | 8-bit normalized code |
| out_range_err_o | output | 1 | Input was negative or above 1.0 |

## Verification
The case hardest to reach is an exact rounding tie. Only one in-range half value, 0.5, scales to an exact .5 fraction, so random stimulus almost never produces it. The bench applies that value directly. It also sweeps every encoding from 0x0000 to 0x3C00 back to back, which covers every subnormal, every shift amount and each boundary of the range flag. Each result is compared against an exact integer model of floor(value·255 + 0.5).

// File: rtl/hf_unorm8_pkg.sv
package hf_unorm8_pkg;
    parameter int HALF_W  = 16;
    parameter int MANT_W  = 10;
    parameter int EXP_W   = 5;
    parameter int OUT_W   = 8;
    parameter int EXP_BIAS = 15;
    parameter logic [HALF_W-2:0] ONE_MAG = 15'h3C00;

    localparam int SIG_W   = MANT_W + 1;
    localparam int PROD_W  = SIG_W + OUT_W;
    localparam int SH_W    = 5;
    // product is sig*2^(e-bias-mant); keep one extra fraction bit for rounding
    localparam int SH_BASE = EXP_BIAS + MANT_W - 1;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] code;
        logic             err;
    } out_reg_t;
endpackage

// File: rtl/hf_field_split.sv
module hf_field_split
    import hf_unorm8_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic [SH_W-1:0]   shamt_o,
    output logic              range_err_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [MANT_W-1:0] mant_f;
    logic              sign_f;

    always_comb begin
        mant_f = half_i[MANT_W-1:0];
        exp_f  = half_i[MANT_W +: EXP_W];
        sign_f = half_i[HALF_W-1];
        // hidden bit is set even for exponent 0; the result still rounds to 0
        sig_o  = {1'b1, mant_f};
        if (int'(exp_f) <= SH_BASE) begin
            shamt_o = SH_W'(SH_BASE - int'(exp_f));
        end else begin
            shamt_o = '0;
        end
        range_err_o = sign_f || (half_i[HALF_W-2:0] > ONE_MAG);
    end
endmodule

// File: rtl/hf_scale255.sv
module hf_scale255 #(
    parameter int IN_W  = 11,
    parameter int SCL_W = 8,
    localparam int RES_W = IN_W + SCL_W
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [RES_W-1:0] y_o
);
    logic [RES_W-1:0] shifted;
    logic [RES_W-1:0] base;

    always_comb begin
        shifted = {x_i, {SCL_W{1'b0}}};
        base    = {{SCL_W{1'b0}}, x_i};
        y_o     = shifted - base;
    end
endmodule

// File: rtl/hf_rsh_barrel.sv
module hf_rsh_barrel #(
    parameter int DW = 19,
    parameter int SW = 5
) (
    input  logic [DW-1:0] d_i,
    input  logic [SW-1:0] sh_i,
    output logic [DW-1:0] q_o
);
    logic [DW-1:0] stg [SW+1];

    assign stg[0] = d_i;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        always_comb begin
            if (sh_i[i]) begin
                stg[i+1] = stg[i] >> (1 << i);
            end else begin
                stg[i+1] = stg[i];
            end
        end
    end

    assign q_o = stg[SW];
endmodule

// File: rtl/hf_unorm8_conv.sv
module hf_unorm8_conv
    import hf_unorm8_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [15:0]       in_half_i,
    output logic              out_valid_o,
    output logic [7:0]        out_unorm_o,
    output logic              out_range_err_o
);
    logic [SIG_W-1:0]  sig;
    logic [SH_W-1:0]   shamt;
    logic              range_err;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [OUT_W:0]    rounded;
    logic              sat;
    out_reg_t          r_d, r_q;

    hf_field_split u_split (
        .half_i      (in_half_i),
        .sig_o       (sig),
        .shamt_o     (shamt),
        .range_err_o (range_err)
    );

    hf_scale255 #(.IN_W(SIG_W), .SCL_W(OUT_W)) u_scale (
        .x_i (sig),
        .y_o (prod)
    );

    hf_rsh_barrel #(.DW(PROD_W), .SW(SH_W)) u_shift (
        .d_i  (prod),
        .sh_i (shamt),
        .q_o  (scaled)
    );

    always_comb begin
        // (t + 1) >> 1 written as (t >> 1) + t[0]
        rounded = {1'b0, scaled[OUT_W:1]} + {{OUT_W{1'b0}}, scaled[0]};
        sat     = (|scaled[PROD_W-1:OUT_W+1]) || rounded[OUT_W];
        r_d     = r_q;
        r_d.vld = in_valid_i;
        if (in_valid_i) begin
            r_d.code = sat ? {OUT_W{1'b1}} : rounded[OUT_W-1:0];
            r_d.err  = range_err;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid_o     = r_q.vld;
    assign out_unorm_o     = r_q.code;
    assign out_range_err_o = r_q.err;

    p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
    p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
    p_one_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_half_i == 16'h3C00) |=> (out_unorm_o == 8'hFF && !out_range_err_o));
    p_subnorm_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_half_i[15:10] == 6'd0) |=> (out_unorm_o == 8'h00));
    p_neg_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_half_i[15]) |=> out_range_err_o);
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> ($stable(out_unorm_o) && $stable(out_range_err_o)));
endmodule

// File: tb/hf_unorm8_conv_tb.sv
module hf_unorm8_conv_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [15:0] in_half_i = '0;
    logic        out_valid_o;
    logic [7:0]  out_unorm_o;
    logic        out_range_err_o;

    int total = 0;
    int bad = 0;

    always #2 clk_i = ~clk_i;

    hf_unorm8_conv dut_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .in_valid_i      (in_valid_i),
        .in_half_i       (in_half_i),
        .out_valid_o     (out_valid_o),
        .out_unorm_o     (out_unorm_o),
        .out_range_err_o (out_range_err_o)
    );

    // exact model: value = n / 2^25, code = floor(value*255 + 1/2)
    function automatic logic [7:0] ref_code(input logic [15:0] h);
        longint unsigned e = longint'(h[14:10]);
        longint unsigned m = longint'(h[9:0]);
        longint unsigned n;
        if (e == 0) n = 2 * m;
        else        n = (1024 + m) << e;
        return 8'((n * 510 + (64'd1 << 25)) >> 26);
    endfunction

    function automatic logic ref_err(input logic [15:0] h);
        return h[15] || (h[14:0] > 15'h3C00);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge: drive one sample, check it at the next negedge
    task automatic apply(input string req, input logic [15:0] h);
        in_valid_i = 1'b1;
        in_half_i  = h;
        @(negedge clk_i);
        check({req, " vld"}, 32'(out_valid_o), 32'd1);
        check({req, " err"}, 32'(out_range_err_o), 32'(ref_err(h)));
        if (!ref_err(h)) check({req, " code"}, 32'(out_unorm_o), 32'(ref_code(h)));
    endtask

    task automatic t_reset;
        @(negedge clk_i);
        check("R1 vld", 32'(out_valid_o), 0);
        check("R1 code", 32'(out_unorm_o), 0);
        check("R1 err", 32'(out_range_err_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 vld after release", 32'(out_valid_o), 0);
        check("R1 code after release", 32'(out_unorm_o), 0);
    endtask

    task automatic t_ends;
        apply("R3 zero", 16'h0000);
        check("R3 zero val", 32'(out_unorm_o), 32'h00);
        apply("R3 one", 16'h3C00);
        check("R3 one val", 32'(out_unorm_o), 32'hFF);
    endtask

    task automatic t_tie;
        apply("R4 tie", 16'h3800);
        check("R4 tie val", 32'(out_unorm_o), 32'h80);
        apply("R4 quarter", 16'h3400);
        check("R4 quarter val", 32'(out_unorm_o), 32'h40);
    endtask

    task automatic t_subnormal;
        apply("R5 min sub", 16'h0001);
        check("R5 min sub val", 32'(out_unorm_o), 0);
        apply("R5 max sub", 16'h03FF);
        check("R5 max sub val", 32'(out_unorm_o), 0);
    endtask

    task automatic t_range;
        apply("R6 neg zero", 16'h8000);
        apply("R6 neg one", 16'hBC00);
        apply("R6 just above", 16'h3C01);
        apply("R6 inf", 16'h7C00);
        apply("R6 nan", 16'h7FFF);
        apply("R6 back in range", 16'h3A00);
        check("R6 cleared", 32'(out_range_err_o), 0);
    endtask

    task automatic t_hold;
        apply("R7 setup", 16'h3555);
        in_valid_i = 1'b0;
        in_half_i  = 16'hBC00;
        @(negedge clk_i);
        check("R7 vld low", 32'(out_valid_o), 0);
        check("R7 code held", 32'(out_unorm_o), 32'(ref_code(16'h3555)));
        check("R7 err held", 32'(out_range_err_o), 0);
        in_half_i = 16'h0000;
        @(negedge clk_i);
        check("R7 code still held", 32'(out_unorm_o), 32'(ref_code(16'h3555)));
    endtask

    task automatic t_sweep;
        for (int v = 0; v <= 16'h3C00; v++) begin
            apply("R4 R8 sweep", 16'(v));
        end
        in_valid_i = 1'b0;
        @(negedge clk_i);
        check("R2 idle after sweep", 32'(out_valid_o), 0);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ends();
        t_tie();
        t_subnormal();
        t_range();
        t_hold();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule